// File: doc/BRIEF.md
# Periodic Whole-Second Drift Corrector

This block sits between a raw one-second tick source and a seconds counter. It either passes each raw tick through unchanged or, at a fixed programmable interval, removes one tick or adds one extra tick. Over time this moves the counted time by exactly one second per interval, so a clock that drifts slowly can be trimmed without retuning its oscillator. With an interval of N+1 seconds, the correction is 1e9/(N+1) parts per billion.

Software programs the corrector by writing one 32-bit configuration word. A write restarts the interval count. When the word enables a correction, the block counts raw ticks. On every (N+1)-th tick it drops that tick (swallow) or emits a second pulse shortly after it (insert). The corrected tick leaves the block through a register, one cycle after the raw tick that caused it.

The controller has four states:
- `ST_OFF`: pass-through, no counting.
- `ST_COUNT`: counting raw ticks.
- `ST_GAP`: the low cycle that separates the two pulses of an insert.
- `ST_EXTRA`: emits the added pulse.

The transitions are:
- A write moves the controller to `ST_COUNT` or to `ST_OFF`, depending on whether the new word enables a correction.
- `ST_COUNT` goes to `ST_GAP` on an interval match in insert mode.
- `ST_GAP` always goes to `ST_EXTRA`.
- `ST_EXTRA` always returns to `ST_COUNT`.

A match in swallow mode keeps the controller in `ST_COUNT` and masks the output. Raw ticks must be at least four cycles apart.

Top module: `sec_trim_adjuster`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `tick_out` is low. After reset the configuration is cleared, so the block passes ticks through.
- R2: The configuration word is decoded as follows: bits 18:0 hold the interval count N, bits 20:19 hold the mode, and bit 23 is the enable. All other bits have no effect.
- R3: With bit 23 at 0, every raw tick appears on `tick_out` exactly one cycle later, and no tick is added or removed.
- R4: With bit 23 at 1 and mode 0 or 1, the block behaves as a pass-through, exactly as in R3.
- R5: With bit 23 at 1 and mode 2 (swallow), the (N+1)-th raw tick after a write, and every (N+1)-th tick after that, produces no output pulse. All other ticks pass with one cycle of latency.
- R6: With bit 23 at 1 and mode 3 (insert), the (N+1)-th raw tick produces a high output one cycle after it, a low output in the cycle after that, and a second high output three cycles after the raw tick. This repeats every N+1 ticks.
- R7: A write clears the interval count, so the next correction falls on the (N+1)-th tick after the write. A raw tick that arrives in the same cycle as a write passes through uncorrected and is not counted.
- R8: With N = 0, every raw tick is corrected: in swallow mode every tick is removed, and in insert mode every tick is doubled.
- R9: `tick_out` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | Raw one-second tick, one cycle wide |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 32 | Configuration word (see R2) |
| tick_out | output | 1 | Corrected one-second tick, one cycle wide |

## Verification
Each wrong internal state shows up at the ports as follows:
- **Interval count off by one, or not cleared on a write.** The correction lands on a neighbouring tick. This becomes visible one cycle after the first raw tick whose output differs from the expected pattern, so each test counts ticks exactly from the write.
- **Stuck or mis-sequenced controller.** A stuck `ST_GAP` or `ST_EXTRA` state shows up within three cycles of an insert match, as a missing second pulse or a merged double-width pulse.
- **Wrongly decoded enable or mode.** A tick goes missing or an extra tick appears at the first match in the affected tests.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // pass-through, interval count idle
        ST_COUNT = 2'd1,   // counting raw ticks toward the match
        ST_GAP   = 2'd2,   // low cycle between the two pulses of an insert
        ST_EXTRA = 2'd3    // emit the inserted pulse
    } trim_state_e;

    localparam int          MODE_W       = 2;
    localparam logic [1:0]  MODE_SWALLOW = 2'd2;
    localparam logic [1:0]  MODE_INSERT  = 2'd3;

endpackage

// File: rtl/sec_trim_cfg.sv
module sec_trim_cfg
    import sec_trim_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int CNT_W     = 19,
    parameter int MODE_LSB  = 19,
    parameter int VALID_BIT = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [CNT_W-1:0] limit,
    output logic             insert,
    output logic             nxt_active
);
    localparam logic [REG_W-1:0] CNT_MASK  = REG_W'((64'd1 << CNT_W) - 64'd1);
    localparam logic [REG_W-1:0] MODE_MASK = REG_W'(64'd3 << MODE_LSB);
    localparam logic [REG_W-1:0] VLD_MASK  = REG_W'(64'd1 << VALID_BIT);
    localparam logic [REG_W-1:0] USED_MASK = CNT_MASK | MODE_MASK | VLD_MASK;

    logic [CNT_W-1:0]  limit_q;
    logic              insert_q;
    logic              active_q;
    logic [MODE_W-1:0] wr_mode;
    logic              wr_active;
    logic              unused_bits;

    assign wr_mode     = wdata[MODE_LSB +: MODE_W];
    assign wr_active   = wdata[VALID_BIT] && (wr_mode == MODE_SWALLOW || wr_mode == MODE_INSERT);
    assign unused_bits = ^(wdata & ~USED_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q  <= '0;
            insert_q <= 1'b0;
            active_q <= 1'b0;
        end else if (wr) begin
            limit_q  <= wdata[CNT_W-1:0];
            insert_q <= (wr_mode == MODE_INSERT);
            active_q <= wr_active;
        end
    end

    assign limit      = limit_q;
    assign insert     = insert_q;
    assign nxt_active = wr ? wr_active : active_q;

endmodule

// File: rtl/sec_trim_interval.sv
module sec_trim_interval #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;

    assign hit = step && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || hit) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sec_trim_fsm.sv
module sec_trim_fsm
    import sec_trim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic wr,
    input  logic nxt_active,
    input  logic insert,
    input  logic hit,
    output logic step,
    output logic tick_out
);
    trim_state_e state_q, state_d;
    logic        out_d;
    logic        out_q;

    assign step = (state_q == ST_COUNT) && tick_in && !wr;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (wr) begin
            state_d = nxt_active ? ST_COUNT : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_COUNT: state_d = (hit && insert) ? ST_GAP : ST_COUNT;
                ST_GAP:   state_d = ST_EXTRA;
                ST_EXTRA: state_d = ST_COUNT;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Output logic
    always_comb begin
        out_d = 1'b0;
        unique case (state_q)
            ST_OFF:   out_d = tick_in;
            ST_COUNT: out_d = tick_in && !(hit && !insert);
            ST_GAP:   out_d = tick_in;
            ST_EXTRA: out_d = 1'b1;
            default:  out_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign tick_out = out_q;

endmodule

// File: rtl/sec_trim_adjuster.sv
module sec_trim_adjuster #(
    parameter int REG_W     = 32,
    parameter int CNT_W     = 19,
    parameter int MODE_LSB  = 19,
    parameter int VALID_BIT = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_data,
    output logic             tick_out
);
    logic [CNT_W-1:0] limit;
    logic             insert;
    logic             nxt_active;
    logic             step;
    logic             hit;

    sec_trim_cfg #(
        .REG_W    (REG_W),
        .CNT_W    (CNT_W),
        .MODE_LSB (MODE_LSB),
        .VALID_BIT(VALID_BIT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wdata     (cfg_data),
        .limit     (limit),
        .insert    (insert),
        .nxt_active(nxt_active)
    );

    sec_trim_interval #(
        .CNT_W(CNT_W)
    ) u_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cfg_wr),
        .step (step),
        .limit(limit),
        .hit  (hit)
    );

    sec_trim_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .wr        (cfg_wr),
        .nxt_active(nxt_active),
        .insert    (insert),
        .hit       (hit),
        .step      (step),
        .tick_out  (tick_out)
    );

endmodule

// File: rtl/sec_trim_checks.sv
module sec_trim_checks #(
    parameter int REG_W     = 32,
    parameter int MODE_LSB  = 19,
    parameter int VALID_BIT = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_in,
    input logic             cfg_wr,
    input logic [REG_W-1:0] cfg_data,
    input logic             tick_out
);
    // Monitor-side view of whether the last written word leaves the block in pass-through.
    logic pass_q;
    logic unused_chk;

    assign unused_chk = ^cfg_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pass_q <= 1'b1;
        else if (cfg_wr) pass_q <= !(cfg_data[VALID_BIT] && cfg_data[MODE_LSB+1]);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !tick_out); // R1

    AST_PASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q |=> (tick_out == $past(tick_in))); // R3

    AST_NO_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |=> !tick_out); // R9

    AST_EXTRA_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && !$past(tick_in)) |-> $past(tick_out, 2)); // R6

endmodule

bind sec_trim_adjuster sec_trim_checks #(
    .REG_W    (REG_W),
    .MODE_LSB (MODE_LSB),
    .VALID_BIT(VALID_BIT)
) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_in),
    .cfg_wr  (cfg_wr),
    .cfg_data(cfg_data),
    .tick_out(tick_out)
);

// File: tb/sec_trim_adjuster_bench.sv
module sec_trim_adjuster_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        tick_out;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    sec_trim_adjuster u_sec_trim_adjuster (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (tick_in),
        .cfg_wr  (cfg_wr),
        .cfg_data(cfg_data),
        .tick_out(tick_out)
    );

    // Word layout from R2: N in 18:0, mode in 20:19, enable at 23.
    function automatic logic [31:0] mk(input logic vld, input logic [1:0] mode, input logic [18:0] n);
        return (32'(vld) << 23) | (32'(mode) << 19) | 32'(n);
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: tick_out=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        cfg_wr = 1'b1;
        cfg_data = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_data = '0;
        @(negedge clk);
    endtask

    // One raw tick; checks the three output cycles that follow it.
    task automatic send_tick(input logic e_first, input logic e_extra, input string req);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        check(tick_out, e_first, req);
        @(negedge clk);
        check(tick_out, 1'b0, req);
        @(negedge clk);
        check(tick_out, e_extra, req);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(tick_out, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(tick_out, 1'b0, "R1 after reset");
        send_tick(1'b1, 1'b0, "R1 passthrough after reset");
    endtask

    task automatic t_invalid;
        write_cfg(mk(1'b0, 2'd3, 19'd1));
        for (int i = 0; i < 4; i++) send_tick(1'b1, 1'b0, "R3 disabled");
        write_cfg(mk(1'b0, 2'd2, 19'd0));
        for (int i = 0; i < 3; i++) send_tick(1'b1, 1'b0, "R3 disabled swallow");
    endtask

    task automatic t_mode01;
        write_cfg(mk(1'b1, 2'd0, 19'd0));
        for (int i = 0; i < 3; i++) send_tick(1'b1, 1'b0, "R4 mode0");
        write_cfg(mk(1'b1, 2'd1, 19'd1));
        for (int i = 0; i < 4; i++) send_tick(1'b1, 1'b0, "R4 mode1");
    endtask

    task automatic t_swallow;
        write_cfg(mk(1'b1, 2'd2, 19'd2));
        for (int i = 1; i <= 7; i++)
            send_tick((i % 3) != 0, 1'b0, "R5 swallow N=2");
    endtask

    task automatic t_insert;
        write_cfg(mk(1'b1, 2'd3, 19'd3));
        for (int i = 1; i <= 9; i++)
            send_tick(1'b1, (i % 4) == 0, "R6 insert N=3");
    endtask

    task automatic t_zero;
        write_cfg(mk(1'b1, 2'd2, 19'd0));
        for (int i = 0; i < 3; i++) send_tick(1'b0, 1'b0, "R8 swallow N=0");
        write_cfg(mk(1'b1, 2'd3, 19'd0));
        for (int i = 0; i < 3; i++) send_tick(1'b1, 1'b1, "R8 insert N=0");
    endtask

    task automatic t_restart;
        write_cfg(mk(1'b1, 2'd2, 19'd3));
        send_tick(1'b1, 1'b0, "R7 before rewrite");
        send_tick(1'b1, 1'b0, "R7 before rewrite");
        write_cfg(mk(1'b1, 2'd2, 19'd3));
        for (int i = 1; i <= 4; i++) send_tick(i != 4, 1'b0, "R7 count cleared");
        // Tick coincident with a write: passes and is not counted.
        cfg_wr = 1'b1;
        cfg_data = mk(1'b1, 2'd2, 19'd1);
        tick_in = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_data = '0;
        tick_in = 1'b0;
        check(tick_out, 1'b1, "R7 tick in write cycle");
        @(negedge clk);
        @(negedge clk);
        send_tick(1'b1, 1'b0, "R7 first after write");
        send_tick(1'b0, 1'b0, "R7 second after write swallowed");
    endtask

    task automatic t_fields;
        // Junk in bits 31:24 and 22:21 must not matter.
        write_cfg(mk(1'b1, 2'd2, 19'd1) | 32'hFF60_0000);
        for (int i = 1; i <= 4; i++) send_tick((i % 2) != 0, 1'b0, "R2 junk bits ignored");
        // Bit 22 set, bit 23 clear: not enabled.
        write_cfg(mk(1'b0, 2'd2, 19'd0) | 32'h0040_0000);
        for (int i = 0; i < 2; i++) send_tick(1'b1, 1'b0, "R2 enable is bit 23");
        // Mode decoded from bits 20:19: bit 20 alone is swallow.
        write_cfg(32'h0090_0000);
        send_tick(1'b0, 1'b0, "R2 mode field position");
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_invalid();
        t_mode01();
        t_swallow();
        t_insert();
        t_zero();
        t_restart();
        t_fields();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule